// File: doc/BRIEF.md
# Periodic-Kick Watchdog Counter

This block supervises running software. A small binary counter advances once for each pulse of a slow tick enable (nominally 2 Hz) that arrives from a separate time-base. If software does not write a kick within the allowed window, the counter wraps past its all-ones value. On that wrap the block raises a one-cycle request that the chip's reset controller turns into a system reset.

Software writes a single data bit through a plain write strobe. A 1 clears the counter and counting resumes from zero on the next tick. A 0 is ignored. The counter value is always visible on the read port, with the kick bit position above it reading as zero.

The counter has no halt input, so it keeps advancing while the processor is halted. A build parameter removes the request output entirely. Every pin is a plain control or status signal. There is no streamed data, so no valid/ready handshake and no back-pressure applies.

Top module: `kick_watchdog`

## Requirements
- R1: While `rst_n` is low, and on the first sample after it is released, the counter bits `rd_data_o[CNT_W-1:0]` are 0 and `rst_req_o` is 0.
- R2: A cycle with `tick_i`=1 and no kick adds 1 (binary) to the counter, visible after that clock edge. With a 2 Hz tick, the counter LSB therefore toggles at 1 Hz.
- R3: A cycle with neither a tick nor a kick leaves the counter unchanged.
- R4: A kick is a cycle with `wr_en_i`=1 and `wr_data_i`=1. It clears the counter to 0 after that edge.
- R5: A write with `wr_en_i`=1 and `wr_data_i`=0 has no effect. The counter holds, or advances by 1 if a tick comes in the same cycle.
- R6: When a kick and a tick fall in the same cycle, the kick wins. The counter becomes 0 and no request is raised, even from the all-ones value.
- R7: A tick without a kick while the counter is all ones (7 for CNT_W=3) wraps the counter to 0. `rst_req_o` is then 1 for exactly the one cycle that follows that edge.
- R8: `rst_req_o` is never high for two consecutive cycles.
- R9: The kick bit position `rd_data_o[CNT_W]` always reads 0.
- R10: With `ENABLE`=0, `rst_req_o` stays 0 at all times, while the counter and its readback behave as in R2 to R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| tick_i | input | 1 | One-cycle enable pulse from the slow time-base |
| wr_en_i | input | 1 | Write strobe for the kick bit |
| wr_data_i | input | 1 | Kick bit value written (1 = kick) |
| rd_data_o | output | CNT_W+1 | {kick bit (reads 0), counter bits} |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds two copies with CNT_W=3 and drives them with the same stimulus. One copy has ENABLE=1 and the other ENABLE=0. With the counter only three bits wide, a full wrap takes just eight ticks, so the timeout request, the kick-versus-tick collision at the all-ones value and the disabled build can all be compared cycle by cycle within a short run. The disabled copy must show an identical count sequence with no request, which confirms that the parameter removes only the reset path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // Per-cycle control decoded from the inputs
  typedef struct packed {
    logic adv;   // tick present
    logic clr;   // kick present
  } wdt_ctl_t;

  localparam logic KICK_VALUE = 1'b1;
endpackage

// File: rtl/wdt_kick_decode.sv
module wdt_kick_decode
  import wdt_pkg::*;
(
  input  logic     tick_i,
  input  logic     wr_en_i,
  input  logic     wr_data_i,
  output wdt_ctl_t ctl_o
);
  always_comb begin
    ctl_o.adv = tick_i;
    ctl_o.clr = wr_en_i && (wr_data_i == KICK_VALUE);
  end
endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  wdt_ctl_t         ctl_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt_q <= '0;
    else if (ctl_i.clr) cnt_q <= '0;          // kick wins over tick
    else if (ctl_i.adv) cnt_q <= cnt_q + CNT_ONE;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = ctl_i.adv && !ctl_i.clr && (cnt_q == CNT_MAX);
endmodule

// File: rtl/wdt_req_gen.sv
module wdt_req_gen #(
  parameter bit ENABLE = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wrap_i,
  output logic req_o
);
  generate
    if (ENABLE) begin : g_on
      logic req_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= wrap_i;
      end
      assign req_o = req_q;
    end else begin : g_off
      assign req_o = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/kick_watchdog.sv
module kick_watchdog
  import wdt_pkg::*;
#(
  parameter int CNT_W  = 3,
  parameter bit ENABLE = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_en_i,
  input  logic             wr_data_i,
  output logic [CNT_W:0]   rd_data_o,
  output logic             rst_req_o
);
  wdt_ctl_t         ctl;
  logic [CNT_W-1:0] cnt;
  logic             wrap;

  wdt_kick_decode u_dec (
    .tick_i    (tick_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (wr_data_i),
    .ctl_o     (ctl)
  );

  wdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_i  (ctl),
    .cnt_o  (cnt),
    .wrap_o (wrap)
  );

  wdt_req_gen #(.ENABLE(ENABLE)) u_req (
    .clk    (clk),
    .rst_n  (rst_n),
    .wrap_i (wrap),
    .req_o  (rst_req_o)
  );

  // Kick bit is write-only: its read position is always 0
  assign rd_data_o = {1'b0, cnt};
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CNT_W  = 3,
  parameter bit ENABLE = 1'b1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           tick_i,
  input logic           wr_en_i,
  input logic           wr_data_i,
  input logic [CNT_W:0] rd_data_o,
  input logic           rst_req_o
);
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  assert_kick_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_data_i) |=> (rd_data_o[CNT_W-1:0] == '0));

  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !(wr_en_i && wr_data_i)) |=> $stable(rd_data_o[CNT_W-1:0]));

  assert_req_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> ($past(tick_i) && !$past(wr_en_i && wr_data_i)
                   && ($past(rd_data_o[CNT_W-1:0]) == ALL_ONES)
                   && (rd_data_o[CNT_W-1:0] == '0)));

  assert_req_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |=> !rst_req_o);

  assert_kick_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data_o[CNT_W] == 1'b0);

  generate
    if (!ENABLE) begin : g_off_chk
      assert_no_req_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req_o);
    end
  endgenerate
endmodule

bind kick_watchdog wdt_checker #(.CNT_W(CNT_W), .ENABLE(ENABLE)) u_wdt_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick_i    (tick_i),
  .wr_en_i   (wr_en_i),
  .wr_data_i (wr_data_i),
  .rd_data_o (rd_data_o),
  .rst_req_o (rst_req_o)
);

// File: tb/kick_watchdog_bench.sv
module kick_watchdog_bench;
  localparam int W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, wr_en = 1'b0, wr_data = 1'b0;
  logic [W:0] rd_on, rd_off;
  logic req_on, req_off;
  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  kick_watchdog #(.CNT_W(W), .ENABLE(1'b1)) u_kick_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_on), .rst_req_o(req_on));

  kick_watchdog #(.CNT_W(W), .ENABLE(1'b0)) u_kick_watchdog_off (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_data_o(rd_off), .rst_req_o(req_off));

  // Vector: [6] tick, [5] wr_en, [4] wr_data, [3:1] expected count, [0] expected request
  localparam int NV = 16;
  localparam logic [6:0] VEC [NV] = '{
    7'b100_001_0,  // R2 tick -> 1
    7'b100_010_0,  // R2 tick -> 2
    7'b000_010_0,  // R3 idle hold
    7'b010_010_0,  // R5 write 0 ignored
    7'b011_000_0,  // R4 kick clears
    7'b111_000_0,  // R6 kick beats tick
    7'b100_001_0,  // R2
    7'b110_010_0,  // R5 write 0 with tick still counts
    7'b100_011_0,
    7'b100_100_0,
    7'b100_101_0,
    7'b100_110_0,
    7'b100_111_0,
    7'b100_000_1,  // R7 wrap raises request
    7'b000_000_0,  // R8 request gone
    7'b100_001_0   // R2 counting resumes
  };

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(input logic t, input logic we, input logic wd);
    @(negedge clk);
    tick = t; wr_en = we; wr_data = wd;
    @(posedge clk);
    #1;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 count in reset", int'(rd_on[W-1:0]), 0);
    chk("R1 req in reset", int'(req_on), 0);
    @(negedge clk) rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 count after release", int'(rd_on[W-1:0]), 0);
    chk("R1 req after release", int'(req_on), 0);

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][6], VEC[i][5], VEC[i][4]);
      chk("R2-table count", int'(rd_on[W-1:0]), int'(VEC[i][3:1]));
      chk("R7 table request", int'(req_on), int'(VEC[i][0]));
      chk("R9 kick bit reads 0", int'(rd_on[W]), 0);
      chk("R10 disabled count", int'(rd_off[W-1:0]), int'(VEC[i][3:1]));
      chk("R10 disabled request", int'(req_off), 0);
    end

    // Directed: reset in mid count (R1)
    step(1'b1, 1'b0, 1'b0);
    step(1'b1, 1'b0, 1'b0);
    @(negedge clk);
    tick = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 mid-count reset", int'(rd_on[W-1:0]), 0);
    @(negedge clk) rst_n = 1'b1;

    // Directed: kick collides with tick at all ones (R6)
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0);
    chk("R2 reached all ones", int'(rd_on[W-1:0]), 7);
    step(1'b1, 1'b1, 1'b1);
    chk("R6 collision count", int'(rd_on[W-1:0]), 0);
    chk("R6 collision no request", int'(req_on), 0);
    step(1'b0, 1'b0, 1'b0);
    chk("R6 no late request", int'(req_on), 0);

    // Directed: back-to-back wraps keep the request single (R8)
    for (int k = 0; k < 8; k++) step(1'b1, 1'b0, 1'b0);
    chk("R7 second wrap request", int'(req_on), 1);
    step(1'b1, 1'b0, 1'b0);
    chk("R8 request one cycle", int'(req_on), 0);
    chk("R2 count after wrap", int'(rd_on[W-1:0]), 1);
    chk("R10 disabled after wraps", int'(req_off), 0);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      summary();
      $finish;
    end
  end
endmodule